// File: doc/BRIEF.md
# Virtual interrupt delivery unit

This block is a per-CPU virtual interrupt controller for 256 vectors. It keeps a request bitmap and an in-service bitmap. It also keeps three 8-bit registers: the requesting vector, the servicing vector and the processor priority. A management port posts requests and can load the requesting vector directly. That load is the software step that picks the first request before the guest runs.

The core side takes vectors over a valid/ready handshake. When a vector is handed out, the block re-evaluates the requesting vector from the requests that remain. A second pending vector can therefore follow without any management action. The block keeps no count of how many times a vector was posted. A vector whose request is still set may be delivered again.

An end-of-interrupt write retires the servicing vector and restores the previous nesting level. If the per-vector exit bitmap flags the retired vector, the write also raises a one-cycle exit pulse carrying that vector.

Top module: `vintr_unit`

## Requirements
- R1: An active-low asynchronous reset clears both bitmaps, the requesting, servicing and priority registers, and the delivery, exit and error outputs.
- R2: A post of vector 16 or above sets that request bit. A post of vector 0..15 changes no state and drives `post_err_o` high for exactly the cycle after the post. A post of vector 16 does not raise the error.
- R3: While no delivery is outstanding, a requesting vector whose class (bits 7:4) is strictly above the priority class is delivered at the next clock edge. At that edge `dlv_vec_o` takes the vector and its in-service bit is set. The servicing register takes the vector, the priority register takes the vector with bits 3:0 cleared, and the vector's request bit is cleared.
- R4: At each delivery, the requesting register becomes the highest request bit still set, or 0 if none remains. The request bit of the delivered vector counts as cleared in this search.
- R5: While `dlv_valid_o` is high and `dlv_ready_i` is low, no further vector is recognized and `dlv_vec_o` holds. After the handshake completes, an eligible vector is delivered.
- R6: A requesting vector whose class is equal to or below the priority class is not delivered.
- R7: An end-of-interrupt write clears the in-service bit of the servicing vector. The servicing register then becomes the highest in-service bit that remains, or 0, and the priority register becomes that value with bits 3:0 cleared. When the servicing register is 0, such a write has no effect.
- R8: When an end-of-interrupt write retires vector v and bit v of `exit_map_i` is set, `exit_valid_o` is high for the next cycle only, with `exit_vec_o` = v. If bit v is clear, no pulse is raised.
- R9: A management load sets the requesting register at the next edge. It overrides the re-evaluation of a delivery at the same edge.
- R10: Duplicate posts of a pending vector collapse into one request. A post that lands at the same edge as that vector's delivery leaves the vector pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| post_valid_i | input | 1 | Post strobe from management |
| post_vec_i | input | 8 | Vector to post |
| rvi_wr_i | input | 1 | Load strobe for the requesting register |
| rvi_wdata_i | input | 8 | Value to load into the requesting register |
| exit_map_i | input | 256 | Per-vector end-of-interrupt exit enables |
| dlv_valid_o | output | 1 | Delivered vector is waiting for the core |
| dlv_vec_o | output | 8 | Delivered vector |
| dlv_ready_i | input | 1 | Core accepts the delivered vector |
| eoi_i | input | 1 | End-of-interrupt write strobe |
| exit_valid_o | output | 1 | One-cycle exit pulse |
| exit_vec_o | output | 8 | Vector that caused the exit |
| post_err_o | output | 1 | A post to a reserved vector was dropped |
| rvi_o | output | 8 | Requesting vector register |
| svi_o | output | 8 | Servicing vector register |
| vppr_o | output | 8 | Priority register (bits 3:0 always zero) |

## Verification
Delivery is tried with three posts at a time in several patterns: vectors in different classes, two vectors sharing the top class, three vectors in one class, and a vector at the lowest legal value. Each pattern shows whether the order of hand-out and the requesting register after each step follow the highest-bit rule, and whether equal classes block each other. Directed sequences cover further cases. Nested service with an exit-flagged vector separates restoring the outer level from clearing to zero. A load during a stalled handshake shows whether recognition is held off. A load at the delivery edge and a post at the delivery edge show the override order and the lack of counting.

// File: rtl/vintr_pkg.sv
package vintr_pkg;
  parameter int unsigned VEC_W   = 8;   // vector index width
  parameter int unsigned CLS_LSB = 4;   // lowest bit of the priority class
  parameter int unsigned MIN_VEC = 16;  // lowest legal vector
endpackage

// File: rtl/vintr_prio_enc.sv
// Highest-set-bit search, single cycle; returns 0 when no bit is set.
module vintr_prio_enc #(
  parameter int unsigned W     = 256,
  parameter int unsigned IDX_W = $clog2(W)
) (
  input  logic [W-1:0]     bits_i,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int unsigned i = 0; i < W; i++) begin
      if (bits_i[i]) idx_o = IDX_W'(i);
    end
  end
endmodule

// File: rtl/vintr_vec_dec.sv
module vintr_vec_dec #(
  parameter int unsigned W     = 256,
  parameter int unsigned IDX_W = $clog2(W)
) (
  input  logic             en_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic [W-1:0]     onehot_o
);
  for (genvar g = 0; g < W; g++) begin : g_bit
    assign onehot_o[g] = en_i && (idx_i == IDX_W'(g));
  end
endmodule

// File: rtl/vintr_dlv_port.sv
// Holds one delivered vector until the core accepts it.
module vintr_dlv_port #(
  parameter int unsigned VEC_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fire_i,
  input  logic [VEC_W-1:0] vec_i,
  input  logic             ready_i,
  output logic             valid_o,
  output logic [VEC_W-1:0] vec_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      vec_o   <= '0;
    end else if (fire_i) begin
      valid_o <= 1'b1;
      vec_o   <= vec_i;
    end else if (ready_i) begin
      valid_o <= 1'b0;
    end
  end
endmodule

// File: rtl/vintr_eoi_trap.sv
module vintr_eoi_trap #(
  parameter int unsigned VEC_W   = 8,
  parameter int unsigned NUM_VEC = 256
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               eoi_act_i,
  input  logic [VEC_W-1:0]   svi_i,
  input  logic [NUM_VEC-1:0] exit_map_i,
  output logic               exit_valid_o,
  output logic [VEC_W-1:0]   exit_vec_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      exit_valid_o <= 1'b0;
      exit_vec_o   <= '0;
    end else begin
      exit_valid_o <= eoi_act_i && exit_map_i[svi_i];
      if (eoi_act_i) exit_vec_o <= svi_i;
    end
  end
endmodule

// File: rtl/vintr_unit.sv
module vintr_unit #(
  parameter  int unsigned VEC_W   = vintr_pkg::VEC_W,
  parameter  int unsigned CLS_LSB = vintr_pkg::CLS_LSB,
  parameter  int unsigned MIN_VEC = vintr_pkg::MIN_VEC,
  localparam int unsigned NUM_VEC = 1 << VEC_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               post_valid_i,
  input  logic [VEC_W-1:0]   post_vec_i,
  input  logic               rvi_wr_i,
  input  logic [VEC_W-1:0]   rvi_wdata_i,
  input  logic [NUM_VEC-1:0] exit_map_i,
  output logic               dlv_valid_o,
  output logic [VEC_W-1:0]   dlv_vec_o,
  input  logic               dlv_ready_i,
  input  logic               eoi_i,
  output logic               exit_valid_o,
  output logic [VEC_W-1:0]   exit_vec_o,
  output logic               post_err_o,
  output logic [VEC_W-1:0]   rvi_o,
  output logic [VEC_W-1:0]   svi_o,
  output logic [VEC_W-1:0]   vppr_o
);
  localparam int unsigned CLS_W = VEC_W - CLS_LSB;

  logic [NUM_VEC-1:0] virr_q, visr_q, virr_d, visr_d, visr_rem;
  logic [NUM_VEC-1:0] post_set, dlv_clr, eoi_clr;
  logic [VEC_W-1:0]   rvi_q, svi_q, vppr_q;
  logic [VEC_W-1:0]   virr_top, visr_top;
  logic [CLS_W-1:0]   rvi_cls, vppr_cls;
  logic               post_ok, post_bad, fire, eoi_act, post_err_q;

  assign post_ok  = post_valid_i && (post_vec_i >= VEC_W'(MIN_VEC));
  assign post_bad = post_valid_i && (post_vec_i <  VEC_W'(MIN_VEC));
  assign rvi_cls  = rvi_q[VEC_W-1:CLS_LSB];
  assign vppr_cls = vppr_q[VEC_W-1:CLS_LSB];
  // new recognition is held off while a delivery waits for the core
  assign fire     = !dlv_valid_o && (rvi_cls > vppr_cls);
  assign eoi_act  = eoi_i && (svi_q != '0);

  vintr_vec_dec #(.W(NUM_VEC), .IDX_W(VEC_W)) u_post_dec (
    .en_i(post_ok), .idx_i(post_vec_i), .onehot_o(post_set));
  vintr_vec_dec #(.W(NUM_VEC), .IDX_W(VEC_W)) u_dlv_dec (
    .en_i(fire), .idx_i(rvi_q), .onehot_o(dlv_clr));
  vintr_vec_dec #(.W(NUM_VEC), .IDX_W(VEC_W)) u_eoi_dec (
    .en_i(eoi_act), .idx_i(svi_q), .onehot_o(eoi_clr));

  // a post landing with its own delivery keeps the request set
  assign virr_d   = (virr_q & ~dlv_clr) | post_set;
  assign visr_rem = visr_q & ~eoi_clr;
  assign visr_d   = visr_rem | dlv_clr;

  vintr_prio_enc #(.W(NUM_VEC), .IDX_W(VEC_W)) u_irr_enc (
    .bits_i(virr_d), .idx_o(virr_top));
  vintr_prio_enc #(.W(NUM_VEC), .IDX_W(VEC_W)) u_isr_enc (
    .bits_i(visr_rem), .idx_o(visr_top));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      virr_q     <= '0;
      visr_q     <= '0;
      rvi_q      <= '0;
      svi_q      <= '0;
      vppr_q     <= '0;
      post_err_q <= 1'b0;
    end else begin
      virr_q     <= virr_d;
      visr_q     <= visr_d;
      post_err_q <= post_bad;
      if (rvi_wr_i)  rvi_q <= rvi_wdata_i;
      else if (fire) rvi_q <= virr_top;
      if (fire) begin
        svi_q  <= rvi_q;
        vppr_q <= {rvi_cls, {CLS_LSB{1'b0}}};
      end else if (eoi_act) begin
        svi_q  <= visr_top;
        vppr_q <= {visr_top[VEC_W-1:CLS_LSB], {CLS_LSB{1'b0}}};
      end
    end
  end

  vintr_dlv_port #(.VEC_W(VEC_W)) u_dlv (
    .clk_i(clk_i), .rst_ni(rst_ni), .fire_i(fire), .vec_i(rvi_q),
    .ready_i(dlv_ready_i), .valid_o(dlv_valid_o), .vec_o(dlv_vec_o));

  vintr_eoi_trap #(.VEC_W(VEC_W), .NUM_VEC(NUM_VEC)) u_trap (
    .clk_i(clk_i), .rst_ni(rst_ni), .eoi_act_i(eoi_act), .svi_i(svi_q),
    .exit_map_i(exit_map_i), .exit_valid_o(exit_valid_o), .exit_vec_o(exit_vec_o));

  assign post_err_o = post_err_q;
  assign rvi_o      = rvi_q;
  assign svi_o      = svi_q;
  assign vppr_o     = vppr_q;
endmodule

// File: rtl/vintr_unit_chk.sv
module vintr_unit_chk #(
  parameter int unsigned VEC_W   = vintr_pkg::VEC_W,
  parameter int unsigned CLS_LSB = vintr_pkg::CLS_LSB,
  parameter int unsigned MIN_VEC = vintr_pkg::MIN_VEC
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             post_valid_i,
  input logic [VEC_W-1:0] post_vec_i,
  input logic             dlv_valid_o,
  input logic [VEC_W-1:0] dlv_vec_o,
  input logic             dlv_ready_i,
  input logic             eoi_i,
  input logic             exit_valid_o,
  input logic [VEC_W-1:0] exit_vec_o,
  input logic             post_err_o,
  input logic [VEC_W-1:0] rvi_o,
  input logic [VEC_W-1:0] svi_o,
  input logic [VEC_W-1:0] vppr_o
);
  p_reset_r1: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> (rvi_o == '0 && svi_o == '0 && vppr_o == '0 &&
                       !dlv_valid_o && !exit_valid_o && !post_err_o));

  p_err_src_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    post_err_o |-> ($past(post_valid_i) && $past(post_vec_i) < VEC_W'(MIN_VEC)));

  p_dlv_state_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dlv_valid_o) |-> (svi_o == dlv_vec_o &&
      vppr_o == {dlv_vec_o[VEC_W-1:CLS_LSB], {CLS_LSB{1'b0}}}));

  p_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dlv_valid_o && !dlv_ready_i) |=> (dlv_valid_o && $stable(dlv_vec_o)));

  p_class_gate_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(dlv_valid_o) |->
      ($past(rvi_o[VEC_W-1:CLS_LSB]) > $past(vppr_o[VEC_W-1:CLS_LSB])));

  p_exit_src_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    exit_valid_o |-> ($past(eoi_i) && $past(svi_o) == exit_vec_o && exit_vec_o != '0));

  p_exit_pulse_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (exit_valid_o && !eoi_i) |=> !exit_valid_o);
endmodule

bind vintr_unit vintr_unit_chk u_chk (.*);

// File: tb/sim_vintr_unit.sv
`timescale 1ns/1ps
module sim_vintr_unit;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic         rst_n, post_valid, rvi_wr, dlv_ready, eoi;
  logic [7:0]   post_vec, rvi_data;
  logic [255:0] exit_map;
  logic         dlv_valid, exit_valid, post_err;
  logic [7:0]   dlv_vec, exit_vec, rvi, svi, vppr;
  int checks = 0;
  int fails  = 0;

  vintr_unit u0 (
    .clk_i(clk), .rst_ni(rst_n), .post_valid_i(post_valid), .post_vec_i(post_vec),
    .rvi_wr_i(rvi_wr), .rvi_wdata_i(rvi_data), .exit_map_i(exit_map),
    .dlv_valid_o(dlv_valid), .dlv_vec_o(dlv_vec), .dlv_ready_i(dlv_ready),
    .eoi_i(eoi), .exit_valid_o(exit_valid), .exit_vec_o(exit_vec),
    .post_err_o(post_err), .rvi_o(rvi), .svi_o(svi), .vppr_o(vppr));

  // {post a, post b, post c, expected order e0, e1, e2}
  localparam logic [47:0] TBL [4] = '{
    48'h20_80_51_80_51_20,
    48'hF0_FF_10_FF_F0_10,
    48'h9A_9C_9B_9C_9B_9A,
    48'h11_E5_47_E5_47_11
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0; post_valid = 0; rvi_wr = 0; dlv_ready = 0; eoi = 0;
    cyc(); cyc();
    rst_n = 1'b1;
    cyc();
  endtask

  task automatic post(input logic [7:0] v);
    post_valid = 1'b1; post_vec = v; cyc(); post_valid = 1'b0;
  endtask

  task automatic wr_rvi(input logic [7:0] v);
    rvi_wr = 1'b1; rvi_data = v; cyc(); rvi_wr = 1'b0;
  endtask

  task automatic do_eoi();
    eoi = 1'b1; cyc(); eoi = 1'b0;
  endtask

  task automatic take(input logic [7:0] exp, input string req);
    for (int n = 0; n < 6 && !dlv_valid; n++) cyc();
    chk({req, " valid"}, dlv_valid, 1);
    chk({req, " vector"}, dlv_vec, exp);
    dlv_ready = 1'b1; cyc(); dlv_ready = 1'b0;
    chk({req, " valid drop"}, dlv_valid, 0);
  endtask

  initial begin
    #500000;
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 0; post_valid = 0; post_vec = 0; rvi_wr = 0; rvi_data = 0;
    dlv_ready = 0; eoi = 0; exit_map = '0;
    do_reset();
    // R1 reset state
    chk("R1 rvi", rvi, 0); chk("R1 svi", svi, 0); chk("R1 vppr", vppr, 0);
    chk("R1 valid", dlv_valid, 0); chk("R1 exit", exit_valid, 0); chk("R1 err", post_err, 0);

    // table walk: R3 R4 R7
    for (int t = 0; t < 4; t++) begin
      logic [7:0] a, b, c, e0, e1, e2;
      {a, b, c, e0, e1, e2} = TBL[t];
      post(a); post(b); post(c); wr_rvi(e0);
      take(e0, "R3");
      chk("R3 svi", svi, e0); chk("R3 vppr", vppr, {e0[7:4], 4'h0});
      chk("R4 rvi next", rvi, e1);
      chk("R6 blocked", dlv_valid, 0);
      do_eoi();
      chk("R7 svi", svi, 0); chk("R7 vppr", vppr, 0);
      take(e1, "R4"); chk("R4 rvi next", rvi, e2);
      do_eoi();
      take(e2, "R4"); chk("R4 rvi empty", rvi, 0);
      do_eoi();
    end

    // R2 reserved vectors
    do_reset();
    post(8'h05); chk("R2 err", post_err, 1);
    cyc(); chk("R2 err clear", post_err, 0);
    post(8'h0F); chk("R2 err 15", post_err, 1);
    post(8'h40); chk("R2 no err", post_err, 0);
    wr_rvi(8'h40); take(8'h40, "R2");
    chk("R2 reserved ignored", rvi, 0);
    do_eoi();
    post(8'h10); chk("R2 err 16", post_err, 0);

    // R6/R7/R8 nesting with exit
    do_reset();
    exit_map = '0; exit_map[8'h9A] = 1'b1; exit_map[0] = 1'b1;
    post(8'h85); wr_rvi(8'h85); take(8'h85, "R3");
    post(8'h8A); wr_rvi(8'h8A); cyc(); cyc(); cyc();
    chk("R6 same class", dlv_valid, 0);
    post(8'h9A); wr_rvi(8'h9A); take(8'h9A, "R3");
    chk("R3 nested svi", svi, 8'h9A);
    chk("R4 rvi", rvi, 8'h8A);
    do_eoi();
    chk("R8 exit", exit_valid, 1); chk("R8 exit vec", exit_vec, 8'h9A);
    chk("R7 restore svi", svi, 8'h85); chk("R7 restore vppr", vppr, 8'h80);
    cyc();
    chk("R8 one cycle", exit_valid, 0);
    chk("R6 still blocked", dlv_valid, 0);
    do_eoi();
    chk("R8 no exit", exit_valid, 0); chk("R7 svi zero", svi, 0);
    take(8'h8A, "R7");
    do_eoi(); cyc();
    do_eoi();
    chk("R7 idle svi", svi, 0); chk("R7 idle vppr", vppr, 0);
    chk("R7 idle no exit", exit_valid, 0);
    exit_map = '0;

    // R5 stalled handshake
    do_reset();
    post(8'h40); post(8'h70); wr_rvi(8'h40); cyc();
    chk("R5 valid", dlv_valid, 1); chk("R5 vec", dlv_vec, 8'h40);
    wr_rvi(8'h70); cyc(); cyc();
    chk("R5 held", dlv_valid, 1); chk("R5 stable", dlv_vec, 8'h40);
    dlv_ready = 1'b1; cyc(); dlv_ready = 1'b0;
    chk("R5 drop", dlv_valid, 0);
    take(8'h70, "R5");
    chk("R4 rvi empty", rvi, 0);

    // R9 load overrides re-evaluation
    do_reset();
    post(8'h60); post(8'h40); wr_rvi(8'h60);
    wr_rvi(8'h70);
    chk("R9 dlv", dlv_valid, 1); chk("R9 dlv vec", dlv_vec, 8'h60);
    chk("R9 rvi", rvi, 8'h70);
    dlv_ready = 1'b1; cyc(); dlv_ready = 1'b0;
    take(8'h70, "R9");
    chk("R4 after load", rvi, 8'h40);

    // R10 no counting
    do_reset();
    post(8'h30); post(8'h30); wr_rvi(8'h30);
    take(8'h30, "R10");
    chk("R10 collapsed", rvi, 0);
    do_eoi();
    do_reset();
    rvi_wr = 1'b1; rvi_data = 8'h30; cyc(); rvi_wr = 1'b0;
    post_valid = 1'b1; post_vec = 8'h30; cyc(); post_valid = 1'b0;
    chk("R10 dlv", dlv_valid, 1); chk("R10 rvi pending", rvi, 8'h30);
    dlv_ready = 1'b1; cyc(); dlv_ready = 1'b0;
    do_eoi();
    take(8'h30, "R10");

    // R1 asynchronous reset mid-run
    post(8'hC0); wr_rvi(8'hC0); cyc();
    rst_n = 1'b0; #1;
    chk("R1 async valid", dlv_valid, 0); chk("R1 async svi", svi, 0);
    chk("R1 async rvi", rvi, 0); chk("R1 async vppr", vppr, 0);
    cyc(); rst_n = 1'b1; cyc();

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule